// File: doc/BRIEF.md
# Aligned Block Transfer Command Splitter

This block sits on the master side of a serial memory-access link. It takes one request to move a block of bytes (start address, byte count, direction) and breaks it into a series of device commands. Each command has one of three sizes: a 2-byte word, a 4-byte word, or a burst that is a multiple of 8 bytes. The block picks the size so that every command address is naturally aligned and the number of commands stays small. It does not drive the serial pins and does not carry the data bytes. It only produces the command descriptors that a downstream shifter executes.

Requests enter on a valid/ready handshake. `req_ready` is high only while the block is idle, so a request held valid during a transfer waits. Commands leave on a second valid/ready handshake. The consumer may hold `cmd_ready` low for any number of cycles. While it does, the block keeps `cmd_valid` high and holds every command field unchanged. One command can complete per cycle. `busy`, `done` and `err` are plain status pins.

Top module: `blk_cmd_splitter`

## Requirements
- R1: A command is 2-byte (length 2) when the current address modulo 8 is 2 or 6, or when exactly 2 bytes remain.
- R2: When R1 does not apply, a command is 4-byte (length 4) when the address modulo 8 is 4, or when 6 or fewer bytes remain.
- R3: In all other cases the command is a burst. Its length is the smaller of the remaining count rounded down to a multiple of 8 and `BURST_MAX` (default 240).
- R4: Opcodes are 3 bits. Bit 0 is the direction (1 = write); bits 2:1 are the size (0 = 2-byte, 1 = 4-byte, 2 = burst). So the reads are 0, 2 and 4, and each write opcode is its read opcode plus one.
- R5: The first command uses the request address. Each later command starts at the previous address plus the previous length. The lengths add up to the (padded) request length, and `cmd_last` is high only on the final command.
- R6: A request with an odd address, or a read with an odd length, is consumed and rejected. `err` is high for exactly the one cycle after acceptance, no command is issued, and the block stays idle.
- R7: A write with an odd length is extended by one byte. `cmd_pad` is high on the final command of that transfer, meaning its last byte is a zero pad byte. `cmd_pad` is low on every other command.
- R8: `done` is a one-cycle pulse in the cycle after the final command handshake. A zero-length request that is accepted produces `done` in the next cycle and issues no command.
- R9: `busy` is high from the cycle after a request is accepted until the final command handshake. `req_ready` is high exactly when `busy` is low, and a request presented while busy is not taken.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_op`, `cmd_addr` and `cmd_len` stay stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| req_write | input | 1 | 1 = write, 0 = read |
| cmd_valid | output | 1 | Command descriptor valid |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_op | output | 3 | Opcode: {size, direction} |
| cmd_addr | output | ADDR_W | Aligned command address |
| cmd_len | output | CNT_W | Bytes in this command |
| cmd_last | output | 1 | Final command of the transfer |
| cmd_pad | output | 1 | Last byte of this command is a zero pad byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
Two events can fall in the same cycle: the completion pulse of one transfer and the acceptance of the next request. The bench provokes this by presenting the second request while the first is still running and holding it valid. The second request must be taken in exactly the cycle where `req_ready` returns, and `done` must be high in that same cycle. The scoreboard then checks that all commands of the first transfer come out before any command of the second. `busy` must rise again in the following cycle.

// File: rtl/blk_split_pkg.sv
package blk_split_pkg;

  typedef enum logic [1:0] {
    SZ_HALF  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_BURST = 2'd2
  } size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;

  function automatic logic [2:0] make_op(size_e sz, logic wr);
    return {sz, wr};
  endfunction

endpackage

// File: rtl/blk_split_check.sv
module blk_split_check #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int REM_W = LEN_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic              wr,
  output logic              ok,
  output logic [REM_W-1:0]  plen,
  output logic              pad
);

  // odd start is never legal; odd count only legal when writing (padded)
  assign ok   = !addr[0] && (wr || !len[0]);
  assign pad  = wr && len[0];
  assign plen = REM_W'(len) + REM_W'(pad);

endmodule

// File: rtl/blk_split_pick.sv
module blk_split_pick
  import blk_split_pkg::*;
#(
  parameter int REM_W     = 17,
  parameter int BURST_MAX = 240,
  parameter int CNT_W     = 8
) (
  input  logic [2:0]       addr_lo,
  input  logic [REM_W-1:0] rem,
  input  logic             wr,
  output size_e            size,
  output logic [2:0]       op,
  output logic [CNT_W-1:0] len
);

  logic [REM_W-1:0] rem_rnd;
  logic             half_ok;
  logic             word_ok;

  assign rem_rnd = rem & ~REM_W'(7);
  assign half_ok = (addr_lo == 3'd2) || (addr_lo == 3'd6) || (rem == REM_W'(2));
  assign word_ok = (addr_lo == 3'd4) || (rem <= REM_W'(6));

  always_comb begin
    if (half_ok) begin
      size = SZ_HALF;
      len  = CNT_W'(2);
    end else if (word_ok) begin
      size = SZ_WORD;
      len  = CNT_W'(4);
    end else begin
      size = SZ_BURST;
      if (rem_rnd > REM_W'(BURST_MAX)) len = CNT_W'(BURST_MAX);
      else                             len = rem_rnd[CNT_W-1:0];
    end
  end

  assign op = make_op(size, wr);

endmodule

// File: rtl/blk_split_track.sv
module blk_split_track
  import blk_split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REM_W  = 17,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic              req_ok,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REM_W-1:0]  req_plen,
  input  logic              req_pad,
  input  logic              req_wr,
  input  logic              cmd_fire,
  input  logic [CNT_W-1:0]  cmd_len,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [REM_W-1:0]  rem,
  output logic              pad_q,
  output logic              wr_q,
  output logic              last,
  output logic              done,
  output logic              err
);

  state_e state;

  assign busy = (state == ST_RUN);
  assign last = (rem == REM_W'(cmd_len));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      rem      <= '0;
      pad_q    <= 1'b0;
      wr_q     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_fire) begin
            if (!req_ok) begin
              err <= 1'b1;
            end else if (req_plen == '0) begin
              done <= 1'b1;
            end else begin
              state    <= ST_RUN;
              cur_addr <= req_addr;
              rem      <= req_plen;
              pad_q    <= req_pad;
              wr_q     <= req_wr;
            end
          end
        end
        ST_RUN: begin
          if (cmd_fire) begin
            cur_addr <= cur_addr + ADDR_W'(cmd_len);
            rem      <= rem - REM_W'(cmd_len);
            if (last) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: a rejection never coexists with an active transfer
  p_err_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  // R8: completion pulse only once the block has returned to idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5: a non-final handshake shrinks the remaining count and stays busy
  p_rem_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && busy && !last) |=> (busy && rem < $past(rem)));

endmodule

// File: rtl/blk_cmd_splitter.sv
module blk_cmd_splitter
  import blk_split_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BURST_MAX = 240,
  parameter int CNT_W     = $clog2(BURST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CNT_W-1:0]  cmd_len,
  output logic              cmd_last,
  output logic              cmd_pad,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int REM_W = LEN_W + 1;

  logic             req_fire;
  logic             cmd_fire;
  logic             chk_ok;
  logic [REM_W-1:0] chk_plen;
  logic             chk_pad;
  logic [REM_W-1:0] rem;
  logic             pad_q;
  logic             wr_q;
  size_e            cmd_size;

  assign req_ready = !busy;
  assign req_fire  = req_valid && req_ready;
  assign cmd_valid = busy;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign cmd_pad   = pad_q && cmd_last;

  blk_split_check #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_check (
    .addr (req_addr),
    .len  (req_len),
    .wr   (req_write),
    .ok   (chk_ok),
    .plen (chk_plen),
    .pad  (chk_pad)
  );

  blk_split_pick #(
    .REM_W     (REM_W),
    .BURST_MAX (BURST_MAX),
    .CNT_W     (CNT_W)
  ) u_pick (
    .addr_lo (cmd_addr[2:0]),
    .rem     (rem),
    .wr      (wr_q),
    .size    (cmd_size),
    .op      (cmd_op),
    .len     (cmd_len)
  );

  blk_split_track #(
    .ADDR_W (ADDR_W),
    .REM_W  (REM_W),
    .CNT_W  (CNT_W)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_fire (req_fire),
    .req_ok   (chk_ok),
    .req_addr (req_addr),
    .req_plen (chk_plen),
    .req_pad  (chk_pad),
    .req_wr   (req_write),
    .cmd_fire (cmd_fire),
    .cmd_len  (cmd_len),
    .busy     (busy),
    .cur_addr (cmd_addr),
    .rem      (rem),
    .pad_q    (pad_q),
    .wr_q     (wr_q),
    .last     (cmd_last),
    .done     (done),
    .err      (err)
  );

  // R1/R2: every presented command is naturally aligned to its size
  p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_len == CNT_W'(2)) |-> !cmd_addr[0]);
  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_len == CNT_W'(4)) |-> (cmd_addr[1:0] == 2'b00));

  // R3: bursts are non-empty multiples of 8, capped, on an 8-byte boundary
  p_burst_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[2]) |->
      (cmd_len <= CNT_W'(BURST_MAX) && cmd_len != '0 &&
       cmd_len[2:0] == 3'b000 && cmd_addr[2:0] == 3'b000));

  // R10: back-pressure keeps the descriptor frozen
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_op)));

  // R8: the final handshake is followed by the completion pulse
  p_last_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_last) |=> done);

  // R5: consecutive commands are contiguous
  p_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !cmd_last) |=>
      (cmd_valid && cmd_addr == $past(cmd_addr) + ADDR_W'($past(cmd_len))));

endmodule

// File: tb/blk_cmd_splitter_tb_top.sv
module blk_cmd_splitter_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 32;
  localparam int LW = 16;
  localparam int BM = 240;
  localparam int CW = $clog2(BM + 1);

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic          req_write;
  logic          cmd_valid;
  logic          cmd_ready;
  logic [2:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [CW-1:0] cmd_len;
  logic          cmd_last;
  logic          cmd_pad;
  logic          busy;
  logic          done;
  logic          err;

  typedef struct {
    logic [2:0]  op;
    logic [31:0] addr;
    int          len;
    logic        last;
    logic        pad;
  } exp_t;

  exp_t expq[$];
  int   checks   = 0;
  int   bad      = 0;
  int   done_cnt = 0;
  int   err_cnt  = 0;
  bit   bp       = 0;

  blk_cmd_splitter #(.ADDR_W(AW), .LEN_W(LW), .BURST_MAX(BM)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_last(cmd_last),
    .cmd_pad(cmd_pad), .busy(busy), .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic string len_req(input int l);
    if (l == 2) return "R1";
    if (l == 4) return "R2";
    return "R3";
  endfunction

  task automatic push_e(input logic [2:0] op, input logic [31:0] a, input int l,
                        input logic lst, input logic pd);
    exp_t e;
    e.op = op; e.addr = a; e.len = l; e.last = lst; e.pad = pd;
    expq.push_back(e);
  endtask

  // expected command list from the selection rules (R1..R5, R7)
  task automatic push_model(input logic [31:0] a, input logic [15:0] l, input logic w);
    int          rem;
    int          sz;
    int          n;
    logic [31:0] cur;
    if (a[0] || (!w && l[0])) return;
    rem = int'(l) + ((w && l[0]) ? 1 : 0);
    cur = a;
    while (rem > 0) begin
      if (cur[2:0] == 3'd2 || cur[2:0] == 3'd6 || rem == 2) begin
        sz = 0; n = 2;
      end else if (cur[2:0] == 3'd4 || rem <= 6) begin
        sz = 1; n = 4;
      end else begin
        sz = 2; n = (rem / 8) * 8;
        if (n > BM) n = BM;
      end
      push_e({sz[1:0], w}, cur, n, rem == n, (w && l[0] && rem == n));
      cur = cur + n;
      rem = rem - n;
    end
  endtask

  // consumer back-pressure
  initial begin
    logic [7:0] lf;
    lf = 8'h5a;
    cmd_ready = 1'b0;
    forever begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      cmd_ready = bp ? lf[0] : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit          st_pend;
    logic [31:0] st_addr;
    logic [CW-1:0] st_len;
    logic [2:0]  st_op;
    exp_t        e;
    st_pend = 0;
    forever begin
      @(negedge clk);
      #1.5;
      if (rst_n) begin
        if (done) done_cnt++;
        if (err)  err_cnt++;
        if (st_pend) begin
          chk(cmd_valid && cmd_addr == st_addr && cmd_len == st_len && cmd_op == st_op,
              "R10", "descriptor held under stall", cmd_addr, st_addr);
          st_pend = 0;
        end
        if (cmd_valid) chk(busy && !req_ready, "R9", "busy while command pending", busy, 1);
        if (cmd_valid && !cmd_ready) begin
          st_pend = 1; st_addr = cmd_addr; st_len = cmd_len; st_op = cmd_op;
        end
        if (cmd_valid && cmd_ready) begin
          if (expq.size() == 0) begin
            chk(0, "R6", "unexpected command", cmd_addr, 0);
          end else begin
            e = expq.pop_front();
            chk(cmd_op == e.op, "R4", "opcode", cmd_op, e.op);
            chk(int'(cmd_len) == e.len, len_req(e.len), "length", cmd_len, e.len);
            chk(cmd_addr == e.addr, "R5", "address", cmd_addr, e.addr);
            chk(cmd_last == e.last, "R5", "last flag", cmd_last, e.last);
            chk(cmd_pad == e.pad, "R7", "pad flag", cmd_pad, e.pad);
          end
        end
      end
    end
  end

  task automatic run_req(input logic [31:0] a, input logic [15:0] l, input logic w,
                         input bit use_model);
    int d0;
    int e0;
    bit rej;
    bit zero;
    rej  = a[0] || (!w && l[0]);
    zero = !rej && (l == 0);
    if (use_model) push_model(a, l, w);
    d0 = done_cnt;
    e0 = err_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l; req_write = w;
    forever begin
      #2;
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    if (rej) begin
      chk(err == 1'b1, "R6", "err pulse after reject", err, 1);
      chk(!cmd_valid && !busy, "R6", "idle after reject", busy, 0);
    end else if (zero) begin
      chk(done == 1'b1, "R8", "done for empty request", done, 1);
      chk(!cmd_valid && !busy, "R8", "no command for empty request", cmd_valid, 0);
    end else begin
      chk(busy && !req_ready, "R9", "busy after accept", busy, 1);
      chk(err == 1'b0, "R6", "no err on legal request", err, 0);
    end
    if (!rej) begin
      while (done_cnt == d0) begin
        @(negedge clk);
        #2;
      end
      chk(!busy && req_ready, "R9", "idle in done cycle", busy, 0);
      chk(expq.size() == 0, "R5", "all commands issued by done", expq.size(), 0);
      @(negedge clk);
      #2;
      chk(done == 1'b0, "R8", "done lasts one cycle", done, 0);
    end else begin
      @(negedge clk);
      #2;
      chk(err == 1'b0 && err_cnt == e0 + 1, "R6", "err lasts one cycle", err_cnt - e0, 1);
      chk(done_cnt == d0, "R6", "no done after reject", done_cnt - d0, 0);
    end
  endtask

  // next request held while busy: taken in the cycle done pulses
  task automatic run_b2b();
    int d0;
    push_model(32'h0000_0010, 16'd20, 1'b0);
    push_model(32'h0000_0022, 16'd12, 1'b1);
    d0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_0010; req_len = 16'd20; req_write = 1'b0;
    forever begin
      #2;
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_addr = 32'h0000_0022; req_len = 16'd12; req_write = 1'b1;
    #2;
    chk(busy && !req_ready, "R9", "held request not taken while busy", req_ready, 0);
    forever begin
      if (req_ready) break;
      @(negedge clk);
      #2;
    end
    chk(done == 1'b1, "R8", "done coincides with next acceptance", done, 1);
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    chk(busy == 1'b1, "R9", "busy again after back-to-back accept", busy, 1);
    while (done_cnt < d0 + 2) begin
      @(negedge clk);
      #2;
    end
    chk(expq.size() == 0, "R5", "both transfers complete in order", expq.size(), 0);
  endtask

  task automatic run_all();
    // R5/R1/R2/R3: the 260-byte read at offset 2, literal expectations
    push_e(3'd0, 32'h6003_0002, 2,   1'b0, 1'b0);
    push_e(3'd2, 32'h6003_0004, 4,   1'b0, 1'b0);
    push_e(3'd4, 32'h6003_0008, 240, 1'b0, 1'b0);
    push_e(3'd4, 32'h6003_00F8, 8,   1'b0, 1'b0);
    push_e(3'd2, 32'h6003_0100, 4,   1'b0, 1'b0);
    push_e(3'd0, 32'h6003_0104, 2,   1'b1, 1'b0);
    run_req(32'h6003_0002, 16'd260, 1'b0, 1'b0);
    run_req(32'h0000_0000, 16'd6, 1'b0, 1'b1);
    run_req(32'h0000_0004, 16'd4, 1'b0, 1'b1);
    run_req(32'h0000_0000, 16'd2, 1'b1, 1'b1);
    bp = 1;
    run_req(32'h5000_0000, 16'd1000, 1'b1, 1'b1);
    run_req(32'h0000_0106, 16'd7, 1'b1, 1'b1);
    run_req(32'h0000_0008, 16'd16, 1'b1, 1'b1);
    run_req(32'h0000_0011, 16'd8, 1'b1, 1'b1);
    run_req(32'h0000_0020, 16'd5, 1'b0, 1'b1);
    run_req(32'h0000_0040, 16'd0, 1'b0, 1'b1);
    run_req(32'h0000_0102, 16'd301, 1'b1, 1'b1);
    bp = 0;
    run_b2b();
    bp = 1;
    run_b2b();
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; req_write = 1'b0;
    repeat (4) @(negedge clk);
    #2;
    chk(!busy && !cmd_valid && req_ready, "R9", "reset idle state", busy, 0);
    chk(!done && !err, "R8", "no pulses in reset", {done, err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R8 watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule